// File: doc/BRIEF.md
# LED Open/Short Detection Controller

This block runs a single fault-detection pass over a row-scanned LED matrix and keeps the per-dot results in a small read-only bank. Software arms it through a 2-bit mode field. The field selects open detection or short detection, and a zero value disarms the block. A run starts only when the field leaves zero. The block then waits for the next frame boundary from the scan sequencer. From there it samples the per-column comparator flags at the end of every row's active period, and it does this for a fixed number of whole frames.

Each dot's result bit is refreshed only if its scale value is nonzero. Dots scaled to zero keep whatever the last run stored. The register block reads the results through a byte-wide address port. Every byte carries six column flags, and each row takes three consecutive bytes.

Top module: `osd_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and every result byte reads 0x00.
- R2: A run is armed only in a cycle where the previous mode value was 00 and the current one is nonzero. Holding a nonzero mode starts no new run, and neither does a change between nonzero values (01 to 11, for example).
- R3: `busy` rises in the cycle after the arming cycle. It stays high through the first `frame_start` pulse, which opens the sampling window, and through `DET_FRAMES` further pulses (default 2). It falls in the cycle after the last of those pulses.
- R4: Result bits change only at the end of a row while the sampling window is open. A row ends in the cycle where its `row_active` bit is 0 after being 1 in the cycle before. Row ends before the window opens, or after a run finishes, leave the results unchanged. The results stay held until they are rewritten by a later run or cleared.
- R5: Mode 01 or 11 selects open detection, which stores `col_open`. Mode 10 selects short detection, which stores `col_short`. The kind is fixed at the arming cycle. The stored value is the flag seen in the row's last active cycle.
- R6: A dot whose `scale_nz` bit is 0 keeps its previous result bit during a run. The bit for row r, column c is at index r*18+c.
- R7: Addresses 0x03 to 0x1A return result bytes. The byte at address 0x03+3*r+g holds columns 6g to 6g+5 of row r in bits D5:D0, with the lowest column in D0, and D7:D6 read as 0. Every other address reads 0x00.
- R8: A one-cycle `soft_clr` clears all results to 0 and ends any run. `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Register-reset strobe; clears results and aborts a run |
| det_mode | input | 2 | Detection mode field: 00 off, 01/11 open, 10 short |
| frame_start | input | 1 | One-cycle pulse at the start of each scan frame |
| row_active | input | 8 | One-hot active row from the scan sequencer |
| col_open | input | 18 | Per-column open-fault comparator flags |
| col_short | input | 18 | Per-column short-fault comparator flags |
| scale_nz | input | 144 | Per-dot nonzero-scale flags, index row*18+column |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` (combinational) |
| busy | output | 1 | High from arming until the detection window closes |

## Verification
The bench targets the arming edge in several forms: the mode held nonzero, the mode changed 01 to 11, and the mode cleared and then set to short. A design that triggers on level or on any mode change would overwrite results that should stay held. Row ends that occur after arming but before the first frame boundary are driven with distinct flag patterns. Sampling them would show up as wrong bytes in an early readout. The comparator flags change in the gap cycle after each row, so a design that samples one cycle late captures the gap pattern. Zero-scale dots are mixed into a short-detection run, where a design that ignores the scale flag clears the bits stored by the earlier open run.

// File: rtl/osd_pkg.sv
package osd_pkg;

   typedef enum logic [1:0] {
      OSD_IDLE  = 2'd0,
      OSD_ALIGN = 2'd1,
      OSD_RUN   = 2'd2
   } osd_state_e;

   localparam logic [1:0] MODE_OFF   = 2'b00;
   localparam logic [1:0] MODE_SHORT = 2'b10;

   function automatic logic mode_is_short(input logic [1:0] m);
      return (m == MODE_SHORT);
   endfunction

endpackage

// File: rtl/osd_arm.sv
module osd_arm
   import osd_pkg::*;
#(
   parameter int DET_FRAMES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic [1:0] det_mode,
   input  logic       frame_start,
   output logic       busy,
   output logic       win_open,
   output logic       kind_short,
   output logic       arm_pulse
);

   localparam int CNT_W = (DET_FRAMES > 1) ? $clog2(DET_FRAMES) : 1;

   if (DET_FRAMES < 1) begin : g_bad_frames
      $error("osd_arm: DET_FRAMES must be at least 1");
   end

   osd_state_e       state;
   logic [1:0]       mode_q;
   logic [CNT_W-1:0] frm_cnt;

   assign arm_pulse = (mode_q == MODE_OFF) && (det_mode != MODE_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= OSD_IDLE;
         mode_q     <= MODE_OFF;
         frm_cnt    <= '0;
         kind_short <= 1'b0;
      end else if (clr) begin
         state      <= OSD_IDLE;
         mode_q     <= MODE_OFF;
         frm_cnt    <= '0;
         kind_short <= 1'b0;
      end else begin
         mode_q <= det_mode;
         if (arm_pulse) begin
            state      <= OSD_ALIGN;
            frm_cnt    <= '0;
            kind_short <= mode_is_short(det_mode);
         end else begin
            case (state)
               OSD_ALIGN: if (frame_start) state <= OSD_RUN;
               OSD_RUN: begin
                  if (frame_start) begin
                     if (frm_cnt == CNT_W'(DET_FRAMES - 1)) begin
                        state   <= OSD_IDLE;
                        frm_cnt <= '0;
                     end else begin
                        frm_cnt <= frm_cnt + 1'b1;
                     end
                  end
               end
               default: state <= OSD_IDLE;
            endcase
         end
      end
   end

   assign busy     = (state != OSD_IDLE);
   assign win_open = (state == OSD_RUN);

endmodule

// File: rtl/osd_store.sv
module osd_store #(
   parameter int ROWS = 8,
   parameter int COLS = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 win_open,
   input  logic                 kind_short,
   input  logic [ROWS-1:0]      row_active,
   input  logic [COLS-1:0]      col_open,
   input  logic [COLS-1:0]      col_short,
   input  logic [ROWS*COLS-1:0] scale_nz,
   output logic [ROWS*COLS-1:0] res_flat
);

   logic [ROWS-1:0] row_q;
   logic [COLS-1:0] open_q;
   logic [COLS-1:0] short_q;

   // Flags of the previous cycle are the last values seen while a row was active.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         open_q  <= '0;
         short_q <= '0;
      end else begin
         row_q   <= row_active;
         open_q  <= col_open;
         short_q <= col_short;
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] bits_q;
      logic [COLS-1:0] pick;
      logic [COLS-1:0] keep_mask;
      logic            row_end;

      assign row_end   = row_q[r] & ~row_active[r];
      assign pick      = kind_short ? short_q : open_q;
      assign keep_mask = scale_nz[r*COLS +: COLS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q <= '0;
         end else if (clr) begin
            bits_q <= '0;
         end else if (win_open && row_end) begin
            bits_q <= (pick & keep_mask) | (bits_q & ~keep_mask);
         end
      end

      assign res_flat[r*COLS +: COLS] = bits_q;
   end

endmodule

// File: rtl/osd_rdmux.sv
module osd_rdmux #(
   parameter int ROWS   = 8,
   parameter int COLS   = 18,
   parameter int GROUP  = 6,
   parameter int BASE   = 3,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic [ROWS*COLS-1:0] res_flat,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data
);

   localparam int NUM_BYTES = (ROWS * COLS) / GROUP;

   if ((COLS % GROUP) != 0) begin : g_bad_group
      $error("osd_rdmux: COLS must be a multiple of GROUP");
   end
   if (GROUP >= DATA_W) begin : g_bad_width
      $error("osd_rdmux: GROUP must be narrower than DATA_W");
   end
   if ((BASE + NUM_BYTES) > (1 << ADDR_W)) begin : g_bad_span
      $error("osd_rdmux: result bank does not fit the address space");
   end

   logic [DATA_W-1:0] bank [NUM_BYTES];

   // Row r, group g lands at byte r*(COLS/GROUP)+g, i.e. bits k*GROUP of the flat vector.
   for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
      assign bank[k] = {{(DATA_W-GROUP){1'b0}}, res_flat[k*GROUP +: GROUP]};
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_BYTES; k++) begin
         if (rd_addr == ADDR_W'(BASE + k)) rd_data = bank[k];
      end
   end

endmodule

// File: rtl/osd_ctrl.sv
module osd_ctrl #(
   parameter int ROWS       = 8,
   parameter int COLS       = 18,
   parameter int GROUP      = 6,
   parameter int BASE       = 3,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int DET_FRAMES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_clr,
   input  logic [1:0]           det_mode,
   input  logic                 frame_start,
   input  logic [ROWS-1:0]      row_active,
   input  logic [COLS-1:0]      col_open,
   input  logic [COLS-1:0]      col_short,
   input  logic [ROWS*COLS-1:0] scale_nz,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 busy
);

   logic                 win_open;
   logic                 kind_short;
   logic                 arm_pulse;
   logic [ROWS*COLS-1:0] res_flat;

   osd_arm #(.DET_FRAMES(DET_FRAMES)) u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_clr),
      .det_mode   (det_mode),
      .frame_start(frame_start),
      .busy       (busy),
      .win_open   (win_open),
      .kind_short (kind_short),
      .arm_pulse  (arm_pulse)
   );

   osd_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_clr),
      .win_open  (win_open),
      .kind_short(kind_short),
      .row_active(row_active),
      .col_open  (col_open),
      .col_short (col_short),
      .scale_nz  (scale_nz),
      .res_flat  (res_flat)
   );

   osd_rdmux #(
      .ROWS(ROWS), .COLS(COLS), .GROUP(GROUP),
      .BASE(BASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_rdmux (
      .res_flat(res_flat),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/osd_ctrl_chk.sv
module osd_ctrl_chk #(
   parameter int ROWS   = 8,
   parameter int COLS   = 18,
   parameter int DATA_W = 8,
   parameter int GROUP  = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 soft_clr,
   input logic [1:0]           det_mode,
   input logic                 frame_start,
   input logic [ROWS*COLS-1:0] scale_nz,
   input logic [DATA_W-1:0]    rd_data,
   input logic                 busy,
   input logic                 win_open,
   input logic [ROWS*COLS-1:0] res_flat
);

   // R2
   arm_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(det_mode) != 2'b00));

   // R3
   busy_end_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(frame_start) || $past(soft_clr)));

   // R4
   hold_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(win_open) && !$past(soft_clr)) |-> $stable(res_flat));

   // R6
   zero_scale_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(soft_clr) |-> (((res_flat ^ $past(res_flat)) & ~$past(scale_nz)) == '0));

   // R7
   pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:GROUP] == '0);

   // R8
   clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_clr) |-> ((res_flat == '0) && !busy));

endmodule

bind osd_ctrl osd_ctrl_chk #(
   .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .GROUP(GROUP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_clr   (soft_clr),
   .det_mode   (det_mode),
   .frame_start(frame_start),
   .scale_nz   (scale_nz),
   .rd_data    (rd_data),
   .busy       (busy),
   .win_open   (win_open),
   .res_flat   (res_flat)
);

// File: tb/osd_ctrl_bench.sv
`timescale 1ns/1ps
module osd_ctrl_bench;

   localparam int ROWS = 8;
   localparam int COLS = 18;
   localparam int NB   = 24;
   localparam int DETF = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic              soft_clr;
   logic [1:0]        det_mode;
   logic              frame_start;
   logic [ROWS-1:0]   row_active;
   logic [COLS-1:0]   col_open;
   logic [COLS-1:0]   col_short;
   logic [ROWS*COLS-1:0] scale_nz;
   logic [7:0]        rd_addr;
   logic [7:0]        rd_data;
   logic              busy;

   osd_ctrl u_osd_ctrl (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .det_mode(det_mode),
      .frame_start(frame_start), .row_active(row_active), .col_open(col_open),
      .col_short(col_short), .scale_nz(scale_nz), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   // Behavioural reference: phase 0 idle, 1 waiting for frame, 2 sampling.
   int                   m_phase;
   int                   m_frames;
   bit                   m_short;
   bit [1:0]             m_mode_prev;
   bit [ROWS-1:0]        m_row_prev;
   bit [COLS-1:0]        m_open_prev;
   bit [COLS-1:0]        m_short_prev;
   bit [ROWS*COLS-1:0]   m_res;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_frames = 0; m_short = 0; m_mode_prev = 0;
         m_row_prev = 0; m_open_prev = 0; m_short_prev = 0; m_res = 0;
      end else begin
         if (soft_clr) begin
            m_phase = 0; m_frames = 0; m_short = 0; m_mode_prev = 0; m_res = 0;
         end else begin
            if (m_phase == 2) begin
               for (int r = 0; r < ROWS; r++)
                  for (int c = 0; c < COLS; c++)
                     if (m_row_prev[r] && !row_active[r] && scale_nz[r*COLS+c])
                        m_res[r*COLS+c] = m_short ? m_short_prev[c] : m_open_prev[c];
            end
            if (m_mode_prev == 2'b00 && det_mode != 2'b00) begin
               m_phase = 1; m_frames = 0; m_short = (det_mode == 2'b10);
            end else if (m_phase == 1 && frame_start) begin
               m_phase = 2;
            end else if (m_phase == 2 && frame_start) begin
               m_frames++;
               if (m_frames == DETF) begin m_phase = 0; m_frames = 0; end
            end
            m_mode_prev = det_mode;
         end
         m_row_prev   = row_active;
         m_open_prev  = col_open;
         m_short_prev = col_short;
      end
   end

   function automatic logic [7:0] exp_byte(input logic [7:0] a);
      logic [7:0] b;
      b = 8'h00;
      if (a >= 8'h03 && a <= 8'h1A) begin
         int k, r, g;
         k = int'(a) - 3; r = k / 3; g = k % 3;
         for (int i = 0; i < 6; i++) b[i] = m_res[r*COLS + g*6 + i];
      end
      return b;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%02h actual=%02h expected=%02h t=%0t", req, rd_addr, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check("R3 busy per cycle", {7'b0, busy}, {7'b0, (m_phase != 0)});
      check("R4 read per cycle", rd_data, exp_byte(rd_addr));
      rd_addr = (rd_addr >= 8'h1F) ? 8'h00 : rd_addr + 8'h01;
   endtask

   task automatic check_all(input string req);
      logic [7:0] keep;
      keep = rd_addr;
      for (int a = 0; a < 33; a++) begin
         rd_addr = (a == 32) ? 8'hFF : 8'(a);
         #0.2;
         check(req, rd_data, exp_byte(rd_addr));
      end
      rd_addr = keep;
   endtask

   function automatic logic [COLS-1:0] pat(input int seed, input int r);
      logic [31:0] v;
      v = 32'h9E37_79B1 * 32'(seed * 13 + r + 1);
      return v[25:8];
   endfunction

   task automatic scan_rows(input int seed);
      for (int r = 0; r < ROWS; r++) begin
         row_active = ROWS'(1) << r;
         col_open   = pat(seed, r);
         col_short  = pat(seed + 100, r);
         tick(); tick(); tick();
         row_active = '0;
         col_open   = ~pat(seed, r);
         col_short  = ~pat(seed + 100, r);
         tick();
      end
   endtask

   task automatic scan_frame(input int seed);
      frame_start = 1'b1;
      tick();
      frame_start = 1'b0;
      scan_rows(seed);
   endtask

   initial begin
      rst_n = 0; soft_clr = 0; det_mode = 2'b00; frame_start = 0;
      row_active = '0; col_open = '0; col_short = '0; scale_nz = '1; rd_addr = 8'h00;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1: reset state
      check("R1 busy at reset", {7'b0, busy}, 8'h00);
      check_all("R1 reset contents");

      // R4: row ends after arming but before the first frame boundary are ignored
      det_mode = 2'b01;
      tick();
      check("R3 busy after arm", {7'b0, busy}, 8'h01);
      scan_rows(7);
      check_all("R4 pre-window rows");

      // R5 open capture across the window, R3 busy drop
      scan_frame(1);
      scan_frame(2);
      scan_frame(3);
      check("R3 busy after window", {7'b0, busy}, 8'h00);
      check_all("R5 open results");

      // R2: level held, and 01 -> 11, do not re-arm; results held (R4)
      scan_frame(4);
      scan_frame(5);
      det_mode = 2'b11;
      tick();
      check("R2 no arm on 01 to 11", {7'b0, busy}, 8'h00);
      scan_frame(6);
      check_all("R2 results held");

      // R6 + R5 short: zero-scale dots keep open-run results
      for (int i = 0; i < ROWS*COLS; i++) scale_nz[i] = (i % 5) != 2;
      det_mode = 2'b00;
      tick();
      det_mode = 2'b10;
      tick();
      check("R2 arm from 00", {7'b0, busy}, 8'h01);
      scan_frame(8);
      scan_frame(9);
      scan_frame(10);
      check_all("R6 zero-scale keep, R5 short");

      // R8 register clear mid-run
      scale_nz = '1;
      det_mode = 2'b00;
      tick();
      det_mode = 2'b01;
      tick();
      scan_frame(11);
      soft_clr = 1'b1;
      det_mode = 2'b00;
      tick();
      soft_clr = 1'b0;
      tick();
      check("R8 busy after clear", {7'b0, busy}, 8'h00);
      check_all("R8 cleared contents");

      // R7 mapping with mode 11 (open) and a fresh run
      det_mode = 2'b11;
      tick();
      scan_frame(12);
      scan_frame(13);
      scan_frame(14);
      check_all("R7 address map");
      repeat (4) tick();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule